// File: doc/BRIEF.md
# Fused Floating-Point Dot Product

This block takes two vectors of N single-precision floating-point numbers each clock and returns their dot product as one single-precision number, a fixed number of cycles later. Every element pair has its own multiplier, and the N products are summed by a registered binary tree of N-1 adders. Inside the tree the numbers are held as an exponent and a wide two's complement mantissa that is never renormalized. One normalize-and-round stage at the output turns the sum back into the standard 32-bit layout.

Each internal term also carries an operand class: CL_FIN for a finite value, CL_INF for an infinity with its sign, and CL_NAN for not-a-number. The class travels through the tree next to the mantissa. A `unique case` on the class at the output selects between the rounded finite result, a signed infinity and the canonical quiet NaN. Subnormal inputs are treated as zero. The result is always rounded to nearest with ties to even, and no exception flags are produced. Because each product is truncated to a wide mantissa and the sum is rounded only once, the result can differ in its last bits from a chain of separately rounded operations.

N must be a power of two and at least 2; the default is 8, and 32 is also supported. MANT_W sets the internal mantissa width, from 27 to 47 bits, and defaults to 28.

Top module: `fp_dot_product`

## Requirements
- R1: One vector pair is accepted on every cycle that `in_valid` is high, with no gaps needed. `out_valid` goes high exactly LAT = log2(N)+2 rising edges after the matching `in_valid`, and is low otherwise. After reset, `out_valid` and `result` are 0.
- R2: All numbers use the 32-bit layout: sign in bit 31, biased exponent in bits 30:23, fraction in bits 22:0, with the hidden leading one restored on unpack. Element i of each vector sits in bits [32i+31:32i]. A dot product whose exact value fits in 24 significant bits is returned exactly, including negative results.
- R3: Every element pair is multiplied by its own multiplier, and all N products reach the sum. A full vector of distinct values gives the exact sum.
- R4: At each adder, the term with the smaller exponent is shifted right to line up with the larger one. The internal word has log2(N)+2 bits more than MANT_W, so a sum can never overflow.
- R5: The finite result is normalized once and rounded to 23 fraction bits using round to nearest, ties to even. This holds even when the deciding bits come from a term that is 2^24 smaller than another term.
- R6: A result with a biased exponent of 255 or more becomes an infinity of the result's sign. A result with a biased exponent of 0 or less becomes a zero of the result's sign. A subnormal value is never produced.
- R7: The output is the quiet NaN 0x7FC00000 in three cases: any input is a NaN (exponent 255, nonzero fraction), infinity is multiplied by zero, or infinities of opposite sign are added.
- R8: A sum that contains an infinity and no NaN case returns that infinity, keeping its sign (0x7F800000 or 0xFF800000).
- R9: Inputs with exponent field 0 count as zero. A sum that cancels exactly returns +0, and a term that cancels to zero does not prevent smaller terms from being added in full.
- R10: For general inputs, the result differs from the exact real dot product by no more than 2^-20 times the sum of the absolute values of the products.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all registers update on the rising edge |
| rst_n | input | 1 | Active-low asynchronous reset for the valid pipeline and output |
| in_valid | input | 1 | High when the input vectors hold a pair to process |
| vec_a | input | N*32 | First vector, element i in bits [32i+31:32i] |
| vec_b | input | N*32 | Second vector, same layout |
| out_valid | output | 1 | High when `result` holds a dot product |
| result | output | 32 | Dot product in the 32-bit floating-point layout |

## Verification
The main function is driven with several kinds of input:
- Small integer vectors whose exact sums fit the output. These check unpacking, element placement and full-vector summing bit for bit.
- Pairs of terms whose exponents differ by 23 and 24. These put the rounding decision on the guard and sticky bits, and separate ties-to-even from plain rounding up.
- Infinities, NaNs, zeros, subnormal inputs and exact cancellation. These show that the class path overrides the finite path, and that a zero term does not distort later alignment.
- Pseudo-random vectors with mixed signs. These are compared with a real-number reference within the stated tolerance rather than bit for bit, since summation order changes the last bits.

// File: rtl/dotp_pkg.sv
package dotp_pkg;
    // Operand class carried beside every internal term.
    typedef enum logic [1:0] {
        CL_FIN = 2'd0,
        CL_INF = 2'd1,
        CL_NAN = 2'd2
    } cls_e;

    localparam int EXP_W  = 10;           // holds ea + eb (0..510)
    localparam int PROD_W = 48;           // 24 x 24 significand product
    localparam logic [31:0] QNAN = 32'h7FC0_0000;
endpackage

// File: rtl/dotp_mul.sv
module dotp_mul
    import dotp_pkg::*;
#(
    parameter int MANT_W = 28,
    parameter int TW     = 33
) (
    input  logic             clk,
    input  logic [31:0]      a_i,
    input  logic [31:0]      b_i,
    output logic [TW-1:0]    m_o,
    output logic [EXP_W-1:0] e_o,
    output cls_e             cls_o,
    output logic             sgn_o
);
    localparam int DROP = PROD_W - MANT_W;

    logic [7:0]        ea, eb;
    logic [22:0]       fa, fb;
    logic              a_zero, b_zero, a_inf, b_inf, a_nan, b_nan;
    logic [23:0]       ma, mb;
    logic [PROD_W-1:0] prod;
    logic [MANT_W-1:0] mag;
    logic [TW-1:0]     m_pos;
    logic [TW-1:0]     m_nxt;
    logic [EXP_W-1:0]  e_nxt;
    cls_e              cls_nxt;
    logic              sg;

    always_comb begin
        ea     = a_i[30:23];
        eb     = b_i[30:23];
        fa     = a_i[22:0];
        fb     = b_i[22:0];
        a_zero = (ea == 8'd0);
        b_zero = (eb == 8'd0);
        a_inf  = (ea == 8'hFF) && (fa == 23'd0);
        b_inf  = (eb == 8'hFF) && (fb == 23'd0);
        a_nan  = (ea == 8'hFF) && (fa != 23'd0);
        b_nan  = (eb == 8'hFF) && (fb != 23'd0);
        ma     = a_zero ? 24'd0 : {1'b1, fa};
        mb     = b_zero ? 24'd0 : {1'b1, fb};
        prod   = PROD_W'(ma) * PROD_W'(mb);
        // keep the top MANT_W bits, jam the dropped bits into the lsb
        mag    = prod[PROD_W-1 -: MANT_W] | MANT_W'(|prod[DROP-1:0]);
        sg     = a_i[31] ^ b_i[31];
        m_pos  = {{(TW-MANT_W){1'b0}}, mag};

        if (a_zero || b_zero) begin
            m_nxt = '0;
            e_nxt = '0;
        end else begin
            m_nxt = sg ? -m_pos : m_pos;
            e_nxt = EXP_W'(ea) + EXP_W'(eb);
        end

        if (a_nan || b_nan || (a_inf && b_zero) || (b_inf && a_zero))
            cls_nxt = CL_NAN;
        else if (a_inf || b_inf)
            cls_nxt = CL_INF;
        else
            cls_nxt = CL_FIN;
    end

    always_ff @(posedge clk) begin
        m_o   <= m_nxt;
        e_o   <= e_nxt;
        cls_o <= cls_nxt;
        sgn_o <= sg;
    end
endmodule

// File: rtl/dotp_add.sv
module dotp_add
    import dotp_pkg::*;
#(
    parameter int TW = 33
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             vld_i,
    input  logic [TW-1:0]    am_i,
    input  logic [EXP_W-1:0] ae_i,
    input  cls_e             acl_i,
    input  logic             as_i,
    input  logic [TW-1:0]    bm_i,
    input  logic [EXP_W-1:0] be_i,
    input  cls_e             bcl_i,
    input  logic             bs_i,
    output logic [TW-1:0]    m_o,
    output logic [EXP_W-1:0] e_o,
    output cls_e             cls_o,
    output logic             sgn_o
);
    logic                 a_big;
    logic [EXP_W-1:0]     diff, e_big;
    logic signed [TW-1:0] big_m, small_m, small_al;
    logic [TW-1:0]        sum;
    logic [EXP_W-1:0]     e_nxt;
    cls_e                 cls_nxt;
    logic                 sg_nxt;

    always_comb begin
        a_big    = (ae_i >= be_i);
        diff     = a_big ? (ae_i - be_i) : (be_i - ae_i);
        e_big    = a_big ? ae_i : be_i;
        big_m    = a_big ? $signed(am_i) : $signed(bm_i);
        small_m  = a_big ? $signed(bm_i) : $signed(am_i);
        small_al = small_m >>> diff;
        sum      = TW'(big_m + small_al);
        // a cancelled sum drops to the lowest exponent so it cannot mask later terms
        e_nxt    = (sum == '0) ? '0 : e_big;

        if (acl_i == CL_NAN || bcl_i == CL_NAN ||
            (acl_i == CL_INF && bcl_i == CL_INF && as_i != bs_i))
            cls_nxt = CL_NAN;
        else if (acl_i == CL_INF || bcl_i == CL_INF)
            cls_nxt = CL_INF;
        else
            cls_nxt = CL_FIN;
        sg_nxt = (acl_i == CL_INF) ? as_i : bs_i;
    end

    always_ff @(posedge clk) begin
        m_o   <= sum;
        e_o   <= e_nxt;
        cls_o <= cls_nxt;
        sgn_o <= sg_nxt;
    end

    // R4: guard bits leave the sign and the next bit equal, never wrapping
    a_r4_headroom: assert property (@(posedge clk) disable iff (!rst_n)
        vld_i |=> (m_o[TW-1] == m_o[TW-2]));

    // R7: a NaN entering an adder leaves it as NaN
    a_r7_nan_keep: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_i && (acl_i == CL_NAN || bcl_i == CL_NAN)) |=> (cls_o == CL_NAN));
endmodule

// File: rtl/dotp_norm.sv
module dotp_norm
    import dotp_pkg::*;
#(
    parameter int MANT_W = 28,
    parameter int TW     = 33
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             vld_i,
    input  logic [TW-1:0]    m_i,
    input  logic [EXP_W-1:0] e_i,
    input  cls_e             cls_i,
    input  logic             sgn_i,
    output logic             vld_o,
    output logic [31:0]      res_o
);
    // biased output exponent = e + lead_pos - EXP_ADJ
    localparam int EXP_ADJ = 125 + MANT_W;

    logic          neg;
    logic [TW-1:0] mag, sh;
    int            lead;
    int            ex_v;
    logic [22:0]   frac, frac_r;
    logic          guard, sticky, rnd, carry, nonzero;
    logic [31:0]   fin_res, res_nxt;

    always_comb begin
        neg  = m_i[TW-1];
        mag  = neg ? -m_i : m_i;
        lead = 0;
        for (int i = 0; i < TW; i++)
            if (mag[i]) lead = i;
        sh      = mag << (TW - 1 - lead);
        nonzero = sh[TW-1];
        frac    = sh[TW-2 -: 23];
        guard   = sh[TW-25];
        sticky  = |sh[TW-26:0];
        rnd     = guard && (sticky || frac[0]);
        {carry, frac_r} = {1'b0, frac} + 24'(rnd);
        ex_v    = int'(e_i) + lead - EXP_ADJ + int'(carry);

        if (!nonzero)
            fin_res = 32'd0;
        else if (ex_v >= 255)
            fin_res = {neg, 8'hFF, 23'd0};
        else if (ex_v <= 0)
            fin_res = {neg, 31'd0};
        else
            fin_res = {neg, ex_v[7:0], frac_r};

        unique case (cls_i)
            CL_NAN:  res_nxt = QNAN;
            CL_INF:  res_nxt = {sgn_i, 8'hFF, 23'd0};
            CL_FIN:  res_nxt = fin_res;
            default: res_nxt = QNAN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld_o <= 1'b0;
            res_o <= 32'd0;
        end else begin
            vld_o <= vld_i;
            res_o <= res_nxt;
        end
    end

    // R1: output valid follows the last tree level by one edge
    a_r1_valid_step: assert property (@(posedge clk) disable iff (!rst_n)
        vld_i |=> vld_o);
    a_r1_valid_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !vld_i |=> !vld_o);

    // R6: the output is never a subnormal number
    a_r6_no_subnormal: assert property (@(posedge clk) disable iff (!rst_n)
        vld_o |-> !(res_o[30:23] == 8'd0 && res_o[22:0] != 23'd0));

    // R7: a NaN class leaves as the canonical quiet NaN
    a_r7_nan_out: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_i && cls_i == CL_NAN) |=> (res_o == QNAN));

    // R8: an infinity class leaves with all-ones exponent and zero fraction
    a_r8_inf_out: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_i && cls_i == CL_INF) |=> (res_o[30:0] == 31'h7F80_0000));
endmodule

// File: rtl/fp_dot_product.sv
module fp_dot_product
    import dotp_pkg::*;
#(
    parameter int N      = 8,
    parameter int MANT_W = 28
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [N*32-1:0] vec_a,
    input  logic [N*32-1:0] vec_b,
    output logic            out_valid,
    output logic [31:0]     result
);
    localparam int LVL   = $clog2(N);
    localparam int TW    = MANT_W + LVL + 2;
    localparam int NODES = 2 * N - 1;

    // heap-ordered tree: node k has children 2k+1 and 2k+2, leaves at N-1..2N-2
    logic [TW-1:0]    nm [NODES];
    logic [EXP_W-1:0] ne [NODES];
    cls_e             nc [NODES];
    logic             ns [NODES];

    // vpipe[0]: products valid; vpipe[j+1]: tree level j valid
    logic [LVL:0] vpipe;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) vpipe <= '0;
        else        vpipe <= {vpipe[LVL-1:0], in_valid};
    end

    for (genvar i = 0; i < N; i++) begin : g_mul
        dotp_mul #(.MANT_W(MANT_W), .TW(TW)) u_mul (
            .clk   (clk),
            .a_i   (vec_a[32*i +: 32]),
            .b_i   (vec_b[32*i +: 32]),
            .m_o   (nm[N-1+i]),
            .e_o   (ne[N-1+i]),
            .cls_o (nc[N-1+i]),
            .sgn_o (ns[N-1+i])
        );
    end

    for (genvar k = 0; k < N - 1; k++) begin : g_add
        localparam int DEPTH = $clog2(k + 2) - 1;
        dotp_add #(.TW(TW)) u_add (
            .clk   (clk),
            .rst_n (rst_n),
            .vld_i (vpipe[LVL-1-DEPTH]),
            .am_i  (nm[2*k+1]),
            .ae_i  (ne[2*k+1]),
            .acl_i (nc[2*k+1]),
            .as_i  (ns[2*k+1]),
            .bm_i  (nm[2*k+2]),
            .be_i  (ne[2*k+2]),
            .bcl_i (nc[2*k+2]),
            .bs_i  (ns[2*k+2]),
            .m_o   (nm[k]),
            .e_o   (ne[k]),
            .cls_o (nc[k]),
            .sgn_o (ns[k])
        );
    end

    dotp_norm #(.MANT_W(MANT_W), .TW(TW)) u_norm (
        .clk   (clk),
        .rst_n (rst_n),
        .vld_i (vpipe[LVL]),
        .m_i   (nm[0]),
        .e_i   (ne[0]),
        .cls_i (nc[0]),
        .sgn_i (ns[0]),
        .vld_o (out_valid),
        .res_o (result)
    );
endmodule

// File: tb/fp_dot_product_test.sv
module fp_dot_product_test;
    localparam int N    = 8;
    localparam int LAT  = $clog2(N) + 2;
    localparam int HMAX = 1024;
    localparam int NT   = 18;

    logic            clk = 1'b0;
    logic            rst_n;
    logic            in_valid;
    logic [N*32-1:0] vec_a, vec_b;
    logic            out_valid;
    logic [31:0]     result;

    always #2 clk = ~clk;   // 250 MHz

    fp_dot_product #(.N(N)) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .vec_a(vec_a), .vec_b(vec_b),
        .out_valid(out_valid), .result(result)
    );

    int  checks = 0, errors = 0, cyc = 0;
    bit  done = 0;
    logic [31:0] sa [N];
    logic [31:0] sb [N];

    bit          hv    [HMAX];
    bit          hexact[HMAX];
    logic [31:0] hexp  [HMAX];
    real         href  [HMAX];
    real         htol  [HMAX];
    string       hreq  [HMAX];

    typedef struct packed {
        logic [31:0] a0, b0, a1, b1, a2, b2, ex;
        logic [7:0]  rq;
    } vec_t;

    localparam vec_t TBL [NT] = '{
        '{32'h3F800000, 32'h3F800000, 0, 0, 0, 0, 32'h3F800000, 8'd2},  // R2 1*1
        '{32'h40000000, 32'h40400000, 32'h40800000, 32'h40A00000,
          32'hBF800000, 32'h3F800000, 32'h41C80000, 8'd2},              // R2 6+20-1=25
        '{32'h3FC00000, 32'h3FC00000, 0, 0, 0, 0, 32'h40100000, 8'd2},  // R2 1.5*1.5
        '{32'hC0000000, 32'h40400000, 0, 0, 0, 0, 32'hC0C00000, 8'd2},  // R2 -6
        '{32'h3F800000, 32'h3F800000, 32'h33800000, 32'h3F800000,
          0, 0, 32'h3F800000, 8'd5},                                    // R5 tie, even stays
        '{32'h3F800000, 32'h3F800000, 32'h34400000, 32'h3F800000,
          0, 0, 32'h3F800002, 8'd5},                                    // R5 tie, odd rounds up
        '{32'h3F800000, 32'h3F800000, 32'h33C00000, 32'h3F800000,
          0, 0, 32'h3F800001, 8'd5},                                    // R5 above half
        '{32'h7F000000, 32'h40000000, 0, 0, 0, 0, 32'h7F800000, 8'd6},  // R6 overflow +
        '{32'hFF000000, 32'h40000000, 0, 0, 0, 0, 32'hFF800000, 8'd6},  // R6 overflow -
        '{32'h0D800000, 32'h0D800000, 0, 0, 0, 0, 32'h00000000, 8'd6},  // R6 underflow
        '{32'h7FC00001, 32'h3F800000, 0, 0, 0, 0, 32'h7FC00000, 8'd7},  // R7 NaN input
        '{32'h7F800000, 32'h00000000, 0, 0, 0, 0, 32'h7FC00000, 8'd7},  // R7 inf*0
        '{32'h7F800000, 32'h3F800000, 32'hFF800000, 32'h3F800000,
          0, 0, 32'h7FC00000, 8'd7},                                    // R7 inf-inf
        '{32'h7F800000, 32'h3F800000, 32'h40A00000, 32'h40A00000,
          0, 0, 32'h7F800000, 8'd8},                                    // R8 +inf wins
        '{32'hFF800000, 32'h40000000, 32'h40400000, 32'h3F800000,
          0, 0, 32'hFF800000, 8'd8},                                    // R8 -inf wins
        '{32'h007FFFFF, 32'h7F000000, 32'h3F800000, 32'h3F800000,
          0, 0, 32'h3F800000, 8'd9},                                    // R9 subnormal flushed
        '{32'h40400000, 32'h3F800000, 32'hC0400000, 32'h3F800000,
          0, 0, 32'h00000000, 8'd9},                                    // R9 exact cancel
        '{32'h40400000, 32'h3F800000, 32'hC0400000, 32'h3F800000,
          32'h3F800000, 32'h3F800000, 32'h3F800000, 8'd9}               // R9 cancel then 1
    };

    function automatic real f2r(input logic [31:0] w);
        int  ex;
        real v;
        ex = int'(w[30:23]);
        if (ex == 0) return 0.0;
        v = (1.0 + real'(w[22:0]) / 8388608.0) * (2.0 ** (ex - 127));
        return w[31] ? -v : v;
    endfunction

    function automatic real fabs(input real x);
        return (x < 0.0) ? -x : x;
    endfunction

    task automatic check_out();
        int idx;
        real got, d;
        idx = cyc - LAT;
        if (idx < 0) return;
        checks++;
        if (out_valid !== hv[idx]) begin
            errors++;
            $display("FAIL R1 out_valid %b expected %b (cycle %0d)", out_valid, hv[idx], cyc);
        end
        if (!hv[idx]) return;
        checks++;
        if (hexact[idx]) begin
            if (result !== hexp[idx]) begin
                errors++;
                $display("FAIL %s result %h expected %h", hreq[idx], result, hexp[idx]);
            end
        end else begin
            got = f2r(result);
            d   = fabs(got - href[idx]);
            if (d > htol[idx]) begin
                errors++;
                $display("FAIL %s result %e expected %e tol %e", hreq[idx], got, href[idx], htol[idx]);
            end
        end
    endtask

    task automatic step(input bit v, input logic [31:0] ex, input real rf,
                        input real tl, input bit exact, input string rq);
        @(negedge clk);
        check_out();
        hv[cyc] = v; hexp[cyc] = ex; href[cyc] = rf; htol[cyc] = tl;
        hexact[cyc] = exact; hreq[cyc] = rq;
        in_valid = v;
        for (int i = 0; i < N; i++) begin
            vec_a[32*i +: 32] = sa[i];
            vec_b[32*i +: 32] = sb[i];
        end
        cyc++;
    endtask

    task automatic clear_stage();
        for (int i = 0; i < N; i++) begin
            sa[i] = 32'd0;
            sb[i] = 32'd0;
        end
    endtask

    logic [31:0] rs = 32'h1357_9BDF;
    function automatic logic [31:0] xs(input logic [31:0] x);
        logic [31:0] y;
        y = x ^ (x << 13);
        y = y ^ (y >> 17);
        y = y ^ (y << 5);
        return y;
    endfunction

    initial begin
        real ref_v, abs_v, pa, pb;
        rst_n = 1'b0; in_valid = 1'b0; vec_a = '0; vec_b = '0;
        clear_stage();
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        checks++;
        if (out_valid !== 1'b0 || result !== 32'd0) begin
            errors++;
            $display("FAIL R1 reset out_valid %b result %h expected 0 00000000", out_valid, result);
        end
        rst_n = 1'b1;

        // table walk, back to back (R1 streaming)
        for (int t = 0; t < NT; t++) begin
            clear_stage();
            sa[0] = TBL[t].a0; sb[0] = TBL[t].b0;
            sa[1] = TBL[t].a1; sb[1] = TBL[t].b1;
            sa[2] = TBL[t].a2; sb[2] = TBL[t].b2;
            step(1'b1, TBL[t].ex, 0.0, 0.0, 1'b1, $sformatf("R%0d", TBL[t].rq));
        end

        // R1 gap: idle cycles must not raise out_valid
        clear_stage();
        step(1'b0, 32'd0, 0.0, 0.0, 1'b1, "R1");
        step(1'b0, 32'd0, 0.0, 0.0, 1'b1, "R1");

        // R3 full vector: sum of k*k for k=1..8 = 204
        for (int i = 0; i < N; i++) begin
            sa[i] = {1'b0, 8'(127 + $clog2(i + 2) - 1), 23'd0};
            sb[i] = sa[i];
        end
        for (int i = 0; i < N; i++) begin
            int k;
            k = i + 1;
            sa[i] = (k == 1) ? 32'h3F800000 : (k == 2) ? 32'h40000000 :
                    (k == 3) ? 32'h40400000 : (k == 4) ? 32'h40800000 :
                    (k == 5) ? 32'h40A00000 : (k == 6) ? 32'h40C00000 :
                    (k == 7) ? 32'h40E00000 : 32'h41000000;
            sb[i] = sa[i];
        end
        step(1'b1, 32'h434C0000, 0.0, 0.0, 1'b1, "R3");

        // R2 element position: only element 7 carries 2*2
        clear_stage();
        sa[N-1] = 32'h40000000; sb[N-1] = 32'h40000000;
        step(1'b1, 32'h40800000, 0.0, 0.0, 1'b1, "R2");
        clear_stage();
        step(1'b0, 32'd0, 0.0, 0.0, 1'b1, "R1");

        // R10 and R4: pseudo-random mixed-sign vectors, tolerance against real sum
        for (int r = 0; r < 40; r++) begin
            ref_v = 0.0; abs_v = 0.0;
            for (int i = 0; i < N; i++) begin
                rs = xs(rs);
                sa[i] = {rs[31], 8'd120 + {4'd0, rs[3:0]}, rs[26:4]};
                rs = xs(rs);
                sb[i] = {rs[31], 8'd120 + {4'd0, rs[3:0]}, rs[26:4]};
                pa = f2r(sa[i]); pb = f2r(sb[i]);
                ref_v = ref_v + pa * pb;
                abs_v = abs_v + fabs(pa * pb);
            end
            step(1'b1, 32'd0, ref_v, abs_v / 1048576.0 + 1.0e-30, 1'b0, "R10");
        end

        clear_stage();
        for (int d = 0; d < LAT + 2; d++)
            step(1'b0, 32'd0, 0.0, 0.0, 1'b1, "R1");

        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++;
            $display("FAIL R1 watchdog expired, run still active, expected finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule